// File: doc/BRIEF.md
# Timer/Counter with DMA Request Logic

A 16-bit timer/counter that runs up or down between zero and a programmable period. Reaching the end of the range is the update condition. At that point the counter reloads, a one-cycle overflow request is raised for an external DMA controller, and any buffered period or compare value is copied into its active register.

Each of the two compare/capture channels runs in one of two modes. In compare mode the channel pulses its request when the count matches the channel value, and it drives a waveform bit. In capture mode the channel latches the count on an event and holds its request high until software or DMA reads the captured value.

A single event input does one of several things, chosen by a register: start the counter, retrigger it, step it, or trigger a capture. Software and DMA reach the block through a simple valid/write/address/data bus. Interrupt flags are cleared by writing a 1, and each flag has its own enable.

Top module: `tmr_dma_top`

## Requirements
- R1: After reset the count is 0, the period is 0xFFFF, the counter is stopped, all flags and enables are 0, and every request, event, waveform and interrupt output is low.
- R2: With CTRL bit0 (run) = 1 and bit1 (dir) = 0, the count rises by one per cycle. A tick at count == PER reloads 0, and `dma_ovf_o` and `ev_ovf_o` are high for exactly the following cycle.
- R3: With dir = 1, the count falls by one per cycle. A tick at count == 0 reloads PER and produces the same one-cycle overflow request.
- R4: A compare-mode channel (CTRL bit 3+n = 0) whose value equals the count on a tick raises `dma_ch_o[n]` and `ev_ch_o[n]` for one cycle and sets FLAGS bit 1+n.
- R5: A capture-mode channel (CTRL bit 3+n = 1) latches the count on an event when EVCTL = 4. `dma_ch_o[n]` then stays high until CC n (address 8+n) is read, and the read returns the latched count.
- R6: A capture while the previous capture is still unread sets the error flag (FLAGS bit N_CH+1), and the newer count replaces the older one.
- R7: With CTRL bit2 (buffer) = 1, writes to PER and CC go to a buffer. Reads of PER return the active value. The buffered value becomes active at the next update condition.
- R8: With buffering off, a compare value written after a match that lies ahead of the count produces a second match in the same period.
- R9: In compare mode, waveform bit n is set at the update condition and cleared on a match. When both happen on the same tick, the clear wins.
- R10: EVCTL selects the event action. 1 sets run. 2 reloads 0 (up) or PER (down) and sets run. 3 makes the counter tick only on events, one step per event in the dir direction, with no movement otherwise.
- R11: FLAGS (address 3) bits are cleared by writing 1, and writing 0 has no effect. `irq_o` is the OR of FLAGS masked by INTEN (address 4).
- R12: A write to COUNT (address 2) loads the count directly, and a read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| ev_i | input | 1 | Event input |
| wo_o | output | 2 | Waveform bits, one per channel |
| dma_ovf_o | output | 1 | Overflow/underflow DMA request |
| dma_ch_o | output | 2 | Per-channel DMA request |
| ev_ovf_o | output | 1 | Overflow event pulse |
| ev_ch_o | output | 2 | Per-channel match/capture event pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
A wrong count or a wrong reload value shows up on `dma_ovf_o` at the very next update condition. The spacing of overflow pulses across a sweep of periods and both directions exposes an off-by-one within one period. A stale or early-applied buffer shifts the pulse spacing of the period that follows the update. A mishandled capture-valid state shows either as a request that drops before the read or one that stays high after it, visible within a cycle. Waveform state errors appear on `wo_o` at the first match or update after the fault.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_PER     = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_FLAG    = 4'd3;
  localparam logic [ADDR_W-1:0] A_INTEN   = 4'd4;
  localparam logic [ADDR_W-1:0] A_EVCTL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_CC_BASE = 4'd8;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_DIR = 1;
  localparam int unsigned CTRL_BUF = 2;
  localparam int unsigned CTRL_CAP = 3;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_START  = 3'd1,
    EV_RETRIG = 3'd2,
    EV_STEP   = 3'd3,
    EV_CAPT   = 3'd4
  } ev_act_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter import tmr_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             dir_i,
  input  logic             buf_i,
  input  logic             ev_i,
  input  ev_act_e          ev_act_i,
  input  logic             wr_per_i,
  input  logic             wr_count_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] per_o,
  output logic             tick_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] count_q, per_q, pbuf_q, reload;
  logic             pbv_q, tick, at_lim, upd, retrig;

  assign tick   = run_i & ((ev_act_i != EV_STEP) | ev_i);
  assign at_lim = dir_i ? (count_q == '0) : (count_q == per_q);
  assign upd    = tick & at_lim;
  assign retrig = ev_i & (ev_act_i == EV_RETRIG);
  assign reload = dir_i ? per_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (wr_count_i) begin
      count_q <= wdata_i;
    end else if (retrig) begin
      count_q <= reload;
    end else if (tick) begin
      if (upd)        count_q <= reload;
      else if (dir_i) count_q <= count_q - CNT_W'(1);
      else            count_q <= count_q + CNT_W'(1);
    end
  end

  // buffered period: copy at update, a same-cycle write refills the buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '1;
      pbuf_q <= '1;
      pbv_q  <= 1'b0;
    end else begin
      if (upd && pbv_q) begin
        per_q <= pbuf_q;
        pbv_q <= 1'b0;
      end
      if (wr_per_i) begin
        if (buf_i) begin
          pbuf_q <= wdata_i;
          pbv_q  <= 1'b1;
        end else begin
          per_q <= wdata_i;
        end
      end
    end
  end

  assign count_o = count_q;
  assign per_o   = per_q;
  assign tick_o  = tick;
  assign upd_o   = upd;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_mode_i,
  input  logic             buf_i,
  input  logic             tick_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             capt_i,
  input  logic             wr_cc_i,
  input  logic             rd_cc_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cc_o,
  output logic             wo_o,
  output logic             req_o,
  output logic             evo_o,
  output logic             hit_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cc_q, cbuf_q;
  logic             cbv_q, cap_vld_q, match_q, evo_q, wo_q;
  logic             match, capt, err;

  assign match = ~cap_mode_i & tick_i & (count_i == cc_q);
  assign capt  = cap_mode_i & capt_i;
  assign err   = capt & cap_vld_q & ~rd_cc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q   <= '0;
      cbuf_q <= '0;
      cbv_q  <= 1'b0;
    end else begin
      if (upd_i && cbv_q && !cap_mode_i) begin
        cc_q  <= cbuf_q;
        cbv_q <= 1'b0;
      end
      if (capt) begin
        cc_q <= count_i;
      end else if (wr_cc_i) begin
        if (buf_i && !cap_mode_i) begin
          cbuf_q <= wdata_i;
          cbv_q  <= 1'b1;
        end else begin
          cc_q <= wdata_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_vld_q <= 1'b0;
      match_q   <= 1'b0;
      evo_q     <= 1'b0;
      wo_q      <= 1'b0;
    end else begin
      match_q <= match;
      evo_q   <= match | capt;
      if (capt)             cap_vld_q <= 1'b1;
      else if (rd_cc_i)     cap_vld_q <= 1'b0;
      else if (!cap_mode_i) cap_vld_q <= 1'b0;
      if (!cap_mode_i) begin
        if (match)      wo_q <= 1'b0;
        else if (upd_i) wo_q <= 1'b1;
      end
    end
  end

  assign cc_o  = cc_q;
  assign wo_o  = wo_q;
  assign req_o = cap_mode_i ? cap_vld_q : match_q;
  assign evo_o = evo_q;
  assign hit_o = match | capt;
  assign err_o = err;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pkg::*; #(
  parameter  int unsigned CNT_W  = 16,
  parameter  int unsigned N_CH   = 2,
  localparam int unsigned FLAG_W = N_CH + 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_valid_i,
  input  logic                       bus_write_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [CNT_W-1:0]           bus_wdata_i,
  output logic [CNT_W-1:0]           bus_rdata_o,
  input  logic                       ev_i,
  input  logic [CNT_W-1:0]           count_i,
  input  logic [CNT_W-1:0]           per_i,
  input  logic [N_CH-1:0][CNT_W-1:0] cc_i,
  input  logic                       ovf_set_i,
  input  logic [N_CH-1:0]            ch_set_i,
  input  logic [N_CH-1:0]            err_set_i,
  output logic                       run_o,
  output logic                       dir_o,
  output logic                       buf_o,
  output logic [N_CH-1:0]            cap_mode_o,
  output ev_act_e                    ev_act_o,
  output logic                       wr_per_o,
  output logic                       wr_count_o,
  output logic [N_CH-1:0]            wr_cc_o,
  output logic [N_CH-1:0]            rd_cc_o,
  output logic [FLAG_W-1:0]          flags_o,
  output logic                       irq_o
);
  logic              wr, rd, unused_wbits;
  logic [N_CH-1:0]   hit_cc;
  logic              run_q, dir_q, buf_q;
  logic [N_CH-1:0]   cap_q;
  ev_act_e           act_q;
  logic [FLAG_W-1:0] inten_q, flag_q, flag_clr, flag_set;

  assign wr = bus_valid_i & bus_write_i;
  assign rd = bus_valid_i & ~bus_write_i;
  assign unused_wbits = ^bus_wdata_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    assign hit_cc[g]  = (bus_addr_i == A_CC_BASE + ADDR_W'(g));
    assign wr_cc_o[g] = wr & hit_cc[g];
    assign rd_cc_o[g] = rd & hit_cc[g];
  end

  assign wr_per_o   = wr & (bus_addr_i == A_PER);
  assign wr_count_o = wr & (bus_addr_i == A_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      buf_q <= 1'b0;
      cap_q <= '0;
    end else if (wr && bus_addr_i == A_CTRL) begin
      run_q <= bus_wdata_i[CTRL_RUN];
      dir_q <= bus_wdata_i[CTRL_DIR];
      buf_q <= bus_wdata_i[CTRL_BUF];
      cap_q <= bus_wdata_i[CTRL_CAP +: N_CH];
    end else if (ev_i && (act_q == EV_START || act_q == EV_RETRIG)) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= EV_NONE;
      inten_q <= '0;
    end else if (wr) begin
      if (bus_addr_i == A_EVCTL) act_q   <= ev_act_e'(bus_wdata_i[2:0]);
      if (bus_addr_i == A_INTEN) inten_q <= bus_wdata_i[FLAG_W-1:0];
    end
  end

  // set wins over a same-cycle clear
  assign flag_clr = (wr && bus_addr_i == A_FLAG) ? bus_wdata_i[FLAG_W-1:0] : '0;
  assign flag_set = {|err_set_i, ch_set_i, ovf_set_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[CTRL_RUN] = run_q;
        bus_rdata_o[CTRL_DIR] = dir_q;
        bus_rdata_o[CTRL_BUF] = buf_q;
        for (int i = 0; i < N_CH; i++) bus_rdata_o[CTRL_CAP+i] = cap_q[i];
      end
      A_PER:   bus_rdata_o = per_i;
      A_COUNT: bus_rdata_o = count_i;
      A_FLAG:  bus_rdata_o = CNT_W'(flag_q);
      A_INTEN: bus_rdata_o = CNT_W'(inten_q);
      A_EVCTL: bus_rdata_o = CNT_W'(act_q);
      default: begin
        for (int i = 0; i < N_CH; i++)
          if (hit_cc[i]) bus_rdata_o = cc_i[i];
      end
    endcase
  end

  assign run_o      = run_q;
  assign dir_o      = dir_q;
  assign buf_o      = buf_q;
  assign cap_mode_o = cap_q;
  assign ev_act_o   = act_q;
  assign flags_o    = flag_q;
  assign irq_o      = |(flag_q & inten_q);
endmodule

// File: rtl/tmr_dma_top.sv
module tmr_dma_top import tmr_pkg::*; #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              ev_i,
  output logic [N_CH-1:0]   wo_o,
  output logic              dma_ovf_o,
  output logic [N_CH-1:0]   dma_ch_o,
  output logic              ev_ovf_o,
  output logic [N_CH-1:0]   ev_ch_o,
  output logic              irq_o
);
  localparam int unsigned FLAG_W = N_CH + 2;

  logic                       run, dir, buf_en, tick, upd, wr_per, wr_count, capt_ev, ovf_q;
  logic [CNT_W-1:0]           count, per;
  logic [N_CH-1:0][CNT_W-1:0] cc;
  logic [N_CH-1:0]            cap_mode, wr_cc, rd_cc, hit, err_set;
  logic [FLAG_W-1:0]          flags;
  ev_act_e                    ev_act;

  tmr_regs #(.CNT_W(CNT_W), .N_CH(N_CH)) u_regs (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .ev_i,
    .count_i(count), .per_i(per), .cc_i(cc),
    .ovf_set_i(upd), .ch_set_i(hit), .err_set_i(err_set),
    .run_o(run), .dir_o(dir), .buf_o(buf_en), .cap_mode_o(cap_mode), .ev_act_o(ev_act),
    .wr_per_o(wr_per), .wr_count_o(wr_count), .wr_cc_o(wr_cc), .rd_cc_o(rd_cc),
    .flags_o(flags), .irq_o
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .dir_i(dir), .buf_i(buf_en), .ev_i, .ev_act_i(ev_act),
    .wr_per_i(wr_per), .wr_count_i(wr_count), .wdata_i(bus_wdata_i),
    .count_o(count), .per_o(per), .tick_o(tick), .upd_o(upd)
  );

  assign capt_ev = ev_i & (ev_act == EV_CAPT);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni, .cap_mode_i(cap_mode[g]), .buf_i(buf_en), .tick_i(tick), .upd_i(upd),
      .count_i(count), .capt_i(capt_ev), .wr_cc_i(wr_cc[g]), .rd_cc_i(rd_cc[g]),
      .wdata_i(bus_wdata_i), .cc_o(cc[g]), .wo_o(wo_o[g]), .req_o(dma_ch_o[g]),
      .evo_o(ev_ch_o[g]), .hit_o(hit[g]), .err_o(err_set[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= upd;
  end

  assign dma_ovf_o = ovf_q;
  assign ev_ovf_o  = ovf_q;
endmodule

// File: rtl/tmr_dma_chk.sv
module tmr_dma_chk #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned FLAG_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic              dma_ovf_i,
  input logic              irq_i,
  input logic [N_CH-1:0]   dma_ch_i,
  input logic [N_CH-1:0]   cap_mode_i,
  input logic [N_CH-1:0]   rd_cc_i,
  input logic [N_CH-1:0]   err_i,
  input logic [N_CH-1:0]   hit_i,
  input logic [N_CH-1:0]   wo_i,
  input logic [FLAG_W-1:0] flags_i
);
  // R2 / R3
  p_ovf_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> dma_ovf_i);
  p_ovf_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> !dma_ovf_i);
  p_irq_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flags_i != '0));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    p_cap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_ch_i[g] && cap_mode_i[g] && !rd_cc_i[g]) |=> (dma_ch_i[g] || !cap_mode_i[g]));
    p_err_unread_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i[g] |-> dma_ch_i[g]);
    p_wo_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !cap_mode_i[g] && !hit_i[g]) |=> wo_i[g]);
  end
endmodule

bind tmr_dma_top tmr_dma_chk #(.N_CH(N_CH), .FLAG_W(FLAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .dma_ovf_i(dma_ovf_o), .irq_i(irq_o),
  .dma_ch_i(dma_ch_o), .cap_mode_i(cap_mode), .rd_cc_i(rd_cc), .err_i(err_set),
  .hit_i(hit), .wo_i(wo_o), .flags_i(flags)
);

// File: tb/tmr_dma_top_bench.sv
module tmr_dma_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] R_CTRL = 4'd0, R_PER = 4'd1, R_COUNT = 4'd2, R_FLAG = 4'd3,
                         R_INTEN = 4'd4, R_EVCTL = 4'd5, R_CC0 = 4'd8, R_CC1 = 4'd9;

  logic        clk, rst_ni, bus_valid, bus_write, ev;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  wo, dma_ch, ev_ch;
  logic        dma_ovf, ev_ovf, irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;
  logic [15:0] v;

  tmr_dma_top u_tmr_dma_top (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .ev_i(ev),
    .wo_o(wo), .dma_ovf_o(dma_ovf), .dma_ch_o(dma_ch), .ev_ovf_o(ev_ovf), .ev_ch_o(ev_ch),
    .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0; ev = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic pulse_ev();
    ev = 1'b1;
    @(negedge clk);
    ev = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    do_reset();
    // R1
    check("R1 dma_ovf", dma_ovf, 0); check("R1 dma_ch", dma_ch, 0);
    check("R1 wo", wo, 0); check("R1 irq", irq, 0);
    check("R1 ev_ovf", ev_ovf, 0); check("R1 ev_ch", ev_ch, 0);
    rd(R_CTRL, v);  check("R1 ctrl", v, 0);
    rd(R_COUNT, v); check("R1 count", v, 0);
    rd(R_PER, v);   check("R1 per", v, 16'hFFFF);
    rd(R_FLAG, v);  check("R1 flags", v, 0);

    // R2 / R3 / R12 period sweep
    for (int dir = 0; dir < 2; dir++) begin
      for (int p = 0; p < 6; p++) begin
        int k_end;
        k_end = 3 * (p + 1);
        do_reset();
        wr(R_PER, 16'(p));
        wr(R_COUNT, dir ? 16'(p) : 16'd0);
        rd(R_COUNT, v); check("R12 count load", v, dir ? p : 0);
        wr(R_CTRL, 16'(1 | (dir << 1)));
        for (int k = 1; k <= k_end; k++) begin
          @(negedge clk);
          check(dir ? "R3 ovf" : "R2 ovf", dma_ovf, (k % (p + 1)) == 0);
          check(dir ? "R3 ev_ovf" : "R2 ev_ovf", ev_ovf, (k % (p + 1)) == 0);
        end
        wr(R_CTRL, 16'd0);
        rd(R_COUNT, v);
        if (dir == 0) check("R2 count", v, (p == 0) ? 0 : 1);
        else          check("R3 count", v, (p == 0) ? 0 : p - 1);
      end
    end

    // R4 / R9 compare sweep
    for (int c = 0; c < 10; c++) begin
      logic wo_e;
      do_reset();
      wr(R_PER, 16'd9);
      wr(R_CC0, 16'(c));
      wr(R_CTRL, 16'd1);
      wo_e = 1'b0;
      for (int k = 1; k <= 20; k++) begin
        logic m, u;
        @(negedge clk);
        m = ((k % 10) == ((c + 1) % 10));
        u = ((k % 10) == 0);
        if (m) wo_e = 1'b0;
        else if (u) wo_e = 1'b1;
        check("R4 dma_ch0", dma_ch[0], m);
        check("R4 ev_ch0", ev_ch[0], m);
        check("R9 wo0", wo[0], wo_e);
      end
      rd(R_FLAG, v); check("R4 flag", v[1], 1);
    end

    // R8 second match after unbuffered write ahead
    do_reset();
    wr(R_PER, 16'd9);
    wr(R_CC0, 16'd2);
    wr(R_CTRL, 16'd1);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (k == 4) begin bus_valid = 1'b0; bus_write = 1'b0; end
      check("R8 dma_ch0", dma_ch[0], (k == 3) || (k == 7));
      if (k == 3) begin bus_valid = 1'b1; bus_write = 1'b1; bus_addr = R_CC0; bus_wdata = 16'd6; end
    end

    // R7 buffered period
    do_reset();
    wr(R_PER, 16'd5);
    wr(R_CTRL, 16'd5);
    wr(R_PER, 16'd2);
    rd(R_PER, v); check("R7 per active", v, 5);
    for (int k = 3; k <= 12; k++) begin
      @(negedge clk);
      check("R7 ovf", dma_ovf, (k == 6) || (k == 9) || (k == 12));
    end
    rd(R_PER, v); check("R7 per applied", v, 2);

    // R5 capture hold until read
    do_reset();
    wr(R_EVCTL, 16'd4);
    wr(R_CTRL, 16'd16);
    for (int i = 0; i < 3; i++) begin
      logic [15:0] cv;
      cv = 16'(i * 20000 + 123);
      wr(R_COUNT, cv);
      pulse_ev();
      check("R5 req set", dma_ch[1], 1); check("R5 ev pulse", ev_ch[1], 1);
      @(negedge clk);
      check("R5 req held", dma_ch[1], 1); check("R5 ev drop", ev_ch[1], 0);
      @(negedge clk);
      check("R5 req held2", dma_ch[1], 1);
      rd(R_CC1, v); check("R5 value", v, cv);
      check("R5 req cleared", dma_ch[1], 0);
    end
    // R6 capture overflow
    wr(R_FLAG, 16'hF);
    wr(R_COUNT, 16'd7);
    pulse_ev();
    rd(R_FLAG, v); check("R6 no err", v[3], 0);
    wr(R_COUNT, 16'd9);
    pulse_ev();
    rd(R_FLAG, v); check("R6 err", v[3], 1);
    rd(R_CC1, v);  check("R6 newest", v, 9);

    // R10 event actions
    do_reset();
    wr(R_EVCTL, 16'd1);
    pulse_ev();
    repeat (3) @(negedge clk);
    rd(R_COUNT, v); check("R10 start", v, 3);
    wr(R_EVCTL, 16'd2);
    pulse_ev();
    repeat (2) @(negedge clk);
    rd(R_COUNT, v); check("R10 retrig up", v, 2);
    wr(R_PER, 16'd50);
    wr(R_CTRL, 16'd3);
    pulse_ev();
    repeat (2) @(negedge clk);
    rd(R_COUNT, v); check("R10 retrig down", v, 48);
    wr(R_EVCTL, 16'd3);
    wr(R_COUNT, 16'd10);
    repeat (5) @(negedge clk);
    rd(R_COUNT, v); check("R10 step idle", v, 10);
    repeat (3) pulse_ev();
    rd(R_COUNT, v); check("R10 step down", v, 7);
    wr(R_CTRL, 16'd1);
    repeat (2) pulse_ev();
    rd(R_COUNT, v); check("R10 step up", v, 9);

    // R11 flags and interrupt
    do_reset();
    wr(R_PER, 16'd3);
    wr(R_CTRL, 16'd1);
    repeat (6) @(negedge clk);
    wr(R_CTRL, 16'd0);
    check("R11 irq masked", irq, 0);
    rd(R_FLAG, v); check("R11 ovf flag", v[0], 1);
    wr(R_INTEN, 16'd1);
    check("R11 irq on", irq, 1);
    wr(R_FLAG, 16'd0);
    check("R11 write0 ignored", irq, 1);
    wr(R_FLAG, 16'd1);
    check("R11 irq cleared", irq, 0);
    rd(R_FLAG, v); check("R11 flag cleared", v[0], 0);
    wr(R_INTEN, 16'd2);
    check("R11 irq ch flag", irq, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule